// File: doc/BRIEF.md
# Four-Row DRAM Expansion Strobe Glue with Refresh Detection

This block is the glue between a host memory-expansion connector and four rows of dynamic RAM. The host drives a single shared row strobe and a single shared column strobe, both active low, plus a 2-bit row select. The block steers each shared strobe onto the RAS or CAS output of the selected row only and holds the other rows' strobes high. Address and data buses go straight from the connector to the memories and do not pass through this block.

The host's read/write line is not defined during CAS-before-RAS refresh, while the DRAM parts need write-enable high before RAS falls in such a cycle. A latch emulation tells the two cycle types apart. Its data is the shared row strobe and it is enabled by the shared column strobe, so it follows the row strobe while the column strobe is high and holds the row strobe's level once the column strobe falls. A held high level marks a refresh, and write-enable is then forced high. In every other non-idle cycle, write-enable follows the host line. The block also inverts the host read-select line into the DRAM output enable and reports a fixed memory size of 1 MB per row.

All strobe, enable and output-enable outputs are registered on a sampling clock that runs much faster than the host strobes. Each output therefore follows its inputs one clock later.

Top module: `dram_xp_glue`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every RAS and CAS output, write-enable and output-enable are high.
- R2: One cycle after the inputs are sampled, the RAS output of the row numbered by row select (0 to 3, bit i of the output bus is row i) equals the shared row strobe, and all other RAS outputs are high.
- R3: One cycle after sampling, the CAS output of the selected row equals the shared column strobe, and all other CAS outputs are high.
- R4: A refresh starts when the column strobe is sampled low while the latch holds a high row strobe. This covers the column strobe falling first, and also both strobes falling in the same sample. Write-enable is then high, whatever the read/write line does, until the column strobe is sampled high again.
- R5: In a normal cycle (row strobe low before the column strobe falls), write-enable equals the host read/write line (1 = read, 0 = write) one cycle later.
- R6: When both shared strobes are sampled high, write-enable is high in the next cycle.
- R7: Output-enable is the inverse of the host read-select line (1 = read), one cycle later.
- R8: The memory-size output is always 0, meaning 1 MB per row.
- R9: Once the column strobe returns high, the latch is transparent again. If the row strobe is still low at that point, write-enable follows the read/write line, and a refresh has no effect on later normal cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_ras_n_i | input | 1 | Shared row strobe, active low |
| host_cas_n_i | input | 1 | Shared column strobe, active low |
| row_sel_i | input | 2 | Row select |
| host_rw_i | input | 1 | Host read/write, 1 = read |
| host_rdsel_i | input | 1 | Host read select, active high |
| ras_n_o | output | 4 | Per-row RAS, active low |
| cas_n_o | output | 4 | Per-row CAS, active low |
| we_n_o | output | 1 | DRAM write-enable, active low |
| oe_n_o | output | 1 | DRAM output enable, active low |
| msize_o | output | 1 | Row size code, 0 = 1 MB |

## Verification
Two events can land in the same sample: the falling edge of the column strobe, which captures the cycle type, and the falling edge of the row strobe. The bench provokes this by dropping both shared strobes in one step on every row, with the read/write line held low (write). A correct design sees the latch's previous high level, classifies the cycle as a refresh, and keeps write-enable high. The bench also sweeps ordinary RAS-first reads and writes and CAS-first refreshes on all four rows. In those sweeps it toggles the read/write line during refresh and expects write-enable to stay high.

// File: rtl/dxg_pkg.sv
package dxg_pkg;
    typedef enum logic [1:0] {
        CYC_IDLE    = 2'd0,
        CYC_NORMAL  = 2'd1,
        CYC_REFRESH = 2'd2
    } cyc_kind_e;
endpackage

// File: rtl/dxg_strobe_decode.sv
module dxg_strobe_decode #(
    parameter int N_ROWS = 4,
    localparam int SEL_W = $clog2(N_ROWS)
) (
    input  logic              strobe_n_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [N_ROWS-1:0] row_n_o
);
    // Only the addressed row sees the shared strobe; the rest idle high.
    for (genvar i = 0; i < N_ROWS; i++) begin : g_row
        always_comb begin
            row_n_o[i] = (sel_i == SEL_W'(i)) ? strobe_n_i : 1'b1;
        end
    end
endmodule

// File: rtl/dxg_cycle_classifier.sv
module dxg_cycle_classifier
    import dxg_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      ras_n_i,
    input  logic      cas_n_i,
    output cyc_kind_e kind_o
);
    logic held_d, held_q;

    // Sampled emulation of a transparent latch: the column strobe high opens it.
    always_comb begin
        held_d = cas_n_i ? ras_n_i : held_q;
        if (ras_n_i && cas_n_i)
            kind_o = CYC_IDLE;
        else if (!cas_n_i && held_d)
            kind_o = CYC_REFRESH;
        else
            kind_o = CYC_NORMAL;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) held_q <= 1'b1;
        else         held_q <= held_d;
    end

    // Once a refresh is seen it persists until the column strobe rises.
    assert_refresh_persists_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kind_o == CYC_REFRESH) |=> (cas_n_i || kind_o == CYC_REFRESH));
    // A normal cycle never turns into a refresh while the column strobe stays low.
    assert_normal_persists_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kind_o == CYC_NORMAL && !cas_n_i) |=> (cas_n_i || kind_o != CYC_REFRESH));
endmodule

// File: rtl/dram_xp_glue.sv
module dram_xp_glue
    import dxg_pkg::*;
#(
    parameter int N_ROWS = 4,
    localparam int SEL_W = $clog2(N_ROWS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              host_ras_n_i,
    input  logic              host_cas_n_i,
    input  logic [SEL_W-1:0]  row_sel_i,
    input  logic              host_rw_i,
    input  logic              host_rdsel_i,
    output logic [N_ROWS-1:0] ras_n_o,
    output logic [N_ROWS-1:0] cas_n_o,
    output logic              we_n_o,
    output logic              oe_n_o,
    output logic              msize_o
);
    typedef struct packed {
        logic [N_ROWS-1:0] ras_n;
        logic [N_ROWS-1:0] cas_n;
        logic              we_n;
        logic              oe_n;
    } out_t;

    localparam out_t OUT_RST = '{ras_n: '1, cas_n: '1, we_n: 1'b1, oe_n: 1'b1};

    logic [N_ROWS-1:0] ras_dec, cas_dec;
    cyc_kind_e         kind;
    out_t              out_d, out_q;

    dxg_strobe_decode #(.N_ROWS(N_ROWS)) u_ras_dec (
        .strobe_n_i(host_ras_n_i), .sel_i(row_sel_i), .row_n_o(ras_dec));
    dxg_strobe_decode #(.N_ROWS(N_ROWS)) u_cas_dec (
        .strobe_n_i(host_cas_n_i), .sel_i(row_sel_i), .row_n_o(cas_dec));
    dxg_cycle_classifier u_cls (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .ras_n_i(host_ras_n_i), .cas_n_i(host_cas_n_i), .kind_o(kind));

    always_comb begin
        out_d       = out_q;
        out_d.ras_n = ras_dec;
        out_d.cas_n = cas_dec;
        out_d.oe_n  = ~host_rdsel_i;
        unique case (kind)
            CYC_NORMAL: out_d.we_n = host_rw_i;
            default:    out_d.we_n = 1'b1;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= OUT_RST;
        else         out_q <= out_d;
    end

    assign ras_n_o = out_q.ras_n;
    assign cas_n_o = out_q.cas_n;
    assign we_n_o  = out_q.we_n;
    assign oe_n_o  = out_q.oe_n;
    assign msize_o = 1'b0;

    assert_one_ras_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(~ras_n_o));
    assert_one_cas_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(~cas_n_o));
    // A RAS output falling while a CAS output was already low is a refresh.
    assert_we_high_refresh_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((|($past(ras_n_o) & ~ras_n_o)) && !(&$past(cas_n_o))) |-> we_n_o);
    assert_idle_we_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (host_ras_n_i && host_cas_n_i) |=> we_n_o);
    assert_oe_inv_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        host_rdsel_i |=> !oe_n_o);
endmodule

// File: tb/tb_dram_xp_glue.sv
module tb_dram_xp_glue;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ras_n = 1'b1, cas_n = 1'b1, rw = 1'b1, rdsel = 1'b0;
    logic [1:0] sel = 2'd0;
    logic [3:0] ras_o, cas_o;
    logic       we_o, oe_o, msize_o;
    int         total = 0, bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    dram_xp_glue dut (
        .clk_i(clk), .rst_ni(rst_n), .host_ras_n_i(ras_n), .host_cas_n_i(cas_n),
        .row_sel_i(sel), .host_rw_i(rw), .host_rdsel_i(rdsel),
        .ras_n_o(ras_o), .cas_n_o(cas_o), .we_n_o(we_o), .oe_n_o(oe_o), .msize_o(msize_o));

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%b exp=%b", req, act, exp);
        end
    endtask

    function automatic logic [3:0] row_low(input int r, input logic lvl);
        return lvl ? 4'b1111 : (4'b1111 & ~(4'b0001 << r));
    endfunction

    // Drive one sample, then check every output one clock later.
    task automatic step(input int r, input logic rs, input logic cs, input logic w,
                        input logic rd, input logic exp_we, input string we_req);
        @(negedge clk);
        sel = 2'(r); ras_n = rs; cas_n = cs; rw = w; rdsel = rd;
        @(posedge clk); #1;
        chk("R2 ras", ras_o, row_low(r, rs));
        chk("R3 cas", cas_o, row_low(r, cs));
        chk({we_req, " we"}, {3'b0, we_o}, {3'b0, exp_we});
        chk("R7 oe", {3'b0, oe_o}, {3'b0, ~rd});
        chk("R8 msize", {3'b0, msize_o}, 4'b0);
    endtask

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 ras", ras_o, 4'b1111);
        chk("R1 cas", cas_o, 4'b1111);
        chk("R1 we/oe", {2'b0, we_o, oe_o}, 4'b0011);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 post", {cas_o[0], ras_o[0], we_o, oe_o}, 4'b1111);

        for (int r = 0; r < 4; r++) begin
            for (int w = 0; w < 2; w++) begin
                logic rd = logic'(w);
                // RAS-first normal cycle: read (w=1) or write (w=0)
                step(r, 1, 1, w[0], rd, 1'b1, "R6");
                step(r, 0, 1, w[0], rd, w[0], "R5");
                step(r, 0, 0, w[0], rd, w[0], "R5");
                step(r, 1, 1, w[0], 0,  1'b1, "R6");
            end
            // CAS-before-RAS refresh with a hostile, toggling rw line
            step(r, 1, 1, 0, 0, 1'b1, "R6");
            step(r, 1, 0, 0, 0, 1'b1, "R4");
            step(r, 0, 0, 0, 0, 1'b1, "R4");
            step(r, 0, 0, 1, 0, 1'b1, "R4");
            step(r, 0, 0, 0, 1, 1'b1, "R4");
            // column strobe rises first: transparent again
            step(r, 0, 1, 0, 0, 1'b0, "R9");
            step(r, 0, 1, 1, 0, 1'b1, "R9");
            step(r, 1, 1, 0, 0, 1'b1, "R6");
            // simultaneous fall of both strobes counts as refresh
            step(r, 0, 0, 0, 0, 1'b1, "R4 simul");
            step(r, 0, 0, 1, 1, 1'b1, "R4 simul");
            step(r, 1, 1, 0, 0, 1'b1, "R6");
            // following normal write unaffected by refresh
            step(r, 0, 1, 0, 0, 1'b0, "R9");
            step(r, 0, 0, 0, 0, 1'b0, "R9");
            step(r, 1, 1, 0, 0, 1'b1, "R6");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule